// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block converts single bus-cycle requests into pin activity on an asynchronous NAND flash interface. Each request names one cycle: a command byte, an address byte, or a data transfer that is either written to or read from the device. The sequencer drives chip enable, the command and address latch enables, the write and read strobes and the data bus, and returns read data on a response port.

Every strobe width and every turnaround gap comes from a count input, in interface-clock cycles. The count inputs are expected to stay stable while a cycle is in progress. A count of zero always behaves as one clock. The sequencer remembers the kind of the previous cycle and inserts the gap that the pair of cycles calls for. When chip enable has to be asserted anew, a setup interval takes the place of that gap. A ready/busy input is synchronised, and its low-to-high transition is reported as a one-cycle event.

Top module: `nand_cycle_seq`

## Requirements
- R1: During reset and directly after it, ce_n, we_n and re_n are high, cle, ale, dq_oe and rsp_valid are low, dq_out is zero and req_ready is high.
- R2: Kind 0 is a command cycle and asserts cle. Kind 1 is an address cycle and asserts ale. Each stays high for the whole low and high phase of the strobe. Kinds 2 and 3 are data cycles and assert neither. Command and address cycles are always writes, whatever the read flag says.
- R3: req_ready is high only in idle cycles, and a request is accepted on the clock edge that ends an idle cycle with req_valid high. The strobe of a cycle is low for max(1,t_lo) clocks and then high for max(1,t_hi) clocks. Exactly one idle cycle follows before the next request can be accepted.
- R4: A read captures dq_in at the end of the strobe clock number max(1,t_acc), counting the first re_n low clock as 1. If that number exceeds the total strobe length, capture happens in the last high clock instead. rsp_valid is high for the single clock after the capture, with the captured data.
- R5: Between a write strobe and a following read strobe, max(1,t_we2re) gap clocks are inserted with both strobes high. The gap is max(1,t_re2we) for a read followed by a write, and max(1,t_re2re) for a read followed by a read. Two consecutive writes get no gap.
- R6: A data cycle that directly follows an address cycle gets max(1,t_adr2dat) gap clocks, and this gap takes priority over the gap of R5.
- R7: When a request is accepted while ce_n is high, ce_n falls on that edge and max(1,t_cs) setup clocks pass before the first strobe, with no R5 or R6 gap. ce_n rises on the edge that ends an idle cycle without a request.
- R8: A data cycle with req_wide set drives dq_out[7:0] from req_data[7:0] and dq_out[15:8] from req_data[23:16]. A wide read returns dq_in[7:0] in rsp_data[7:0] and dq_in[15:8] in rsp_data[23:16], with all other bits zero. Narrow cycles, and command and address cycles, use only bits 7:0 and zero everything else.
- R9: dq_oe is high, and dq_out holds the write value, for the whole low and high phase of a write strobe. At all other times dq_oe is low and dq_out is zero.
- R10: rb_n passes through two flops. ready_evt is high for exactly one clock when the first flop holds 1 and the second holds 0, so a single low-to-high transition of rb_n gives a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_kind | input | 2 | 0 command, 1 address, 2 or 3 data |
| req_rd | input | 1 | Data cycle is a read |
| req_wide | input | 1 | Data cycle uses the 16-bit bus |
| req_data | input | 32 | Write word |
| rsp_valid | output | 1 | Read word valid, one clock |
| rsp_data | output | 32 | Read word |
| t_lo | input | CW | Strobe low count |
| t_hi | input | CW | Strobe high count |
| t_acc | input | CW | Read capture point |
| t_we2re | input | CW | Write-to-read gap |
| t_re2we | input | CW | Read-to-write gap |
| t_re2re | input | CW | Read-to-read gap |
| t_adr2dat | input | CW | Address-to-data gap |
| t_cs | input | CW | Chip-enable setup count |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 16 | Data bus out |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Data bus in |
| rb_n | input | 1 | Ready/busy, low while busy |
| ready_evt | output | 1 | Ready transition pulse |

## Verification
On every cycle, the assertions check how the pins relate to one another. The two latch enables are never high together, and the two strobes never go low together. Neither strobe goes low while chip enable is high. A write strobe always comes with the bus driven, and a read strobe never does. The response and ready-event pulses are each one clock long. The exact widths, the choice of gap between two cycle kinds, the clamped capture point, the byte packing and the release of chip enable depend on the count inputs and on the order of requests. Only the bench's reference model, compared pin by pin on every clock across the scenarios, shows those.

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_rd,
  input  logic          req_wide,
  input  logic [31:0]   req_data,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  input  logic [CW-1:0] t_lo,
  input  logic [CW-1:0] t_hi,
  input  logic [CW-1:0] t_acc,
  input  logic [CW-1:0] t_we2re,
  input  logic [CW-1:0] t_re2we,
  input  logic [CW-1:0] t_re2re,
  input  logic [CW-1:0] t_adr2dat,
  input  logic [CW-1:0] t_cs,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  input  logic [15:0]   dq_in,
  input  logic          rb_n,
  output logic          ready_evt
);
  localparam int KW = CW + 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_GAP, S_LO, S_HI} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [KW-1:0] k;
  logic [1:0]    cur_kind, last_kind;
  logic          cur_wr, last_wr, cur_wide;
  logic [15:0]   cur_dq;
  logic          rb_s1, rb_s2;
  logic          need_gap;
  logic [CW-1:0] gap;

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  wire unused_bits = ^{req_data[31:24], req_data[15:8]};

  wire          wr_req  = !(req_kind[1] && req_rd);
  wire          wide_req = req_wide && req_kind[1];
  wire          accept  = (st == S_IDLE) && req_valid;
  wire          strobe  = (st == S_LO) || (st == S_HI);
  wire          last_hi = (st == S_HI) && (cnt == '0);
  wire [KW-1:0] acc_e   = (t_acc == '0) ? KW'(1) : KW'(t_acc);
  wire          cap_now = strobe && !cur_wr && ((k == acc_e) || (last_hi && (k < acc_e)));

  always_comb begin
    need_gap = 1'b1;
    gap      = t_re2re;
    if (last_kind == 2'b01 && req_kind[1])
      gap = t_adr2dat;
    else if (last_wr && !wr_req)
      gap = t_we2re;
    else if (!last_wr && wr_req)
      gap = t_re2we;
    else if (!last_wr)
      gap = t_re2re;
    else
      need_gap = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      k         <= '0;
      cur_kind  <= 2'b00;
      cur_wr    <= 1'b1;
      cur_wide  <= 1'b0;
      cur_dq    <= '0;
      last_kind <= 2'b00;
      last_wr   <= 1'b1;
      ce_n      <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            ce_n      <= 1'b0;
            cur_kind  <= req_kind;
            cur_wr    <= wr_req;
            cur_wide  <= wide_req;
            cur_dq    <= wide_req ? {req_data[23:16], req_data[7:0]} : {8'h00, req_data[7:0]};
            last_kind <= req_kind;
            last_wr   <= wr_req;
            k         <= KW'(1);
            if (ce_n) begin
              st  <= S_SETUP;
              cnt <= ld(t_cs);
            end else if (need_gap) begin
              st  <= S_GAP;
              cnt <= ld(gap);
            end else begin
              st  <= S_LO;
              cnt <= ld(t_lo);
            end
          end else begin
            ce_n <= 1'b1;
          end
        end
        S_SETUP, S_GAP: begin
          if (cnt == '0) begin
            st  <= S_LO;
            cnt <= ld(t_lo);
            k   <= KW'(1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_LO: begin
          k <= k + 1'b1;
          if (cnt == '0) begin
            st  <= S_HI;
            cnt <= ld(t_hi);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HI: begin
          k <= k + 1'b1;
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_now;
      if (cap_now)
        rsp_data <= cur_wide ? {8'h00, dq_in[15:8], 8'h00, dq_in[7:0]} : {24'h0, dq_in[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1 <= 1'b1;
      rb_s2 <= 1'b1;
    end else begin
      rb_s1 <= rb_n;
      rb_s2 <= rb_s1;
    end
  end

  assign req_ready = (st == S_IDLE);
  assign cle       = strobe && (cur_kind == 2'b00);
  assign ale       = strobe && (cur_kind == 2'b01);
  assign we_n      = !((st == S_LO) && cur_wr);
  assign re_n      = !((st == S_LO) && !cur_wr);
  assign dq_oe     = strobe && cur_wr;
  assign dq_out    = dq_oe ? cur_dq : 16'h0000;
  assign ready_evt = rb_s1 && !rb_s2;
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic ready_evt
);
  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) (we_n || re_n));
  // R2
  read_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> (!cle && !ale));
  // R7
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) (!we_n || !re_n) |-> !ce_n);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (we_n && re_n && !cle && !ale));
  // R9
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> dq_oe);
  // R9
  read_floats_chk: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> re_n);
  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
  // R10
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ready_evt |=> !ready_evt);
endmodule

bind nand_cycle_seq nand_cycle_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
  .dq_oe(dq_oe), .ready_evt(ready_evt)
);

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'b00;
  logic req_rd = 1'b0;
  logic req_wide = 1'b0;
  logic [31:0] req_data = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [3:0] t_lo = 4'd2, t_hi = 4'd1, t_acc = 4'd2, t_we2re = 4'd3, t_re2we = 4'd2;
  logic [3:0] t_re2re = 4'd1, t_adr2dat = 4'd4, t_cs = 4'd2;
  logic ce_n, cle, ale, we_n, re_n, dq_oe, ready_evt;
  logic [15:0] dq_out;
  logic [15:0] dq_in = 16'h1234;
  logic rb_n = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nand_cycle_seq #(.CW(4)) i_nand_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_rd(req_rd), .req_wide(req_wide), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .t_lo(t_lo), .t_hi(t_hi), .t_acc(t_acc), .t_we2re(t_we2re), .t_re2we(t_re2we),
    .t_re2re(t_re2re), .t_adr2dat(t_adr2dat), .t_cs(t_cs),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n), .ready_evt(ready_evt)
  );

  typedef struct packed {
    logic ce, cle, ale, we, re, oe, idle, cap, wide;
    logic [15:0] dq;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  logic in_idle = 1'b1;
  logic mce = 1'b1;
  logic [1:0] mlast_kind = 2'b00;
  logic mlast_wr = 1'b1;
  logic exp_rv = 1'b0;
  logic [31:0] exp_rd = '0;
  logic m_s1 = 1'b1, m_s2 = 1'b1;

  function automatic exp_t idle_t(input logic c);
    exp_t e;
    e = '0;
    e.ce = c; e.we = 1'b1; e.re = 1'b1; e.idle = 1'b1;
    return e;
  endfunction

  function automatic int eff(input logic [3:0] x);
    return (x == 4'd0) ? 1 : int'(x);
  endfunction

  task automatic build();
    int pre, lo, hi, acc;
    logic wr, wide;
    exp_t e;
    wr = !(req_kind[1] && req_rd);
    wide = req_wide && req_kind[1];
    lo = eff(t_lo);
    hi = eff(t_hi);
    acc = (eff(t_acc) > lo + hi) ? lo + hi : eff(t_acc);
    pre = 0;
    if (mce) pre = eff(t_cs);
    else if (mlast_kind == 2'b01 && req_kind[1]) pre = eff(t_adr2dat);
    else if (mlast_wr && !wr) pre = eff(t_we2re);
    else if (!mlast_wr && wr) pre = eff(t_re2we);
    else if (!mlast_wr && !wr) pre = eff(t_re2re);
    for (int i = 0; i < pre; i++) begin
      e = idle_t(1'b0);
      e.idle = 1'b0;
      q.push_back(e);
    end
    for (int i = 1; i <= lo + hi; i++) begin
      e = '0;
      e.cle = (req_kind == 2'b00);
      e.ale = (req_kind == 2'b01);
      e.we = !((i <= lo) && wr);
      e.re = !((i <= lo) && !wr);
      e.oe = wr;
      e.dq = !wr ? 16'h0 : (wide ? {req_data[23:16], req_data[7:0]} : {8'h00, req_data[7:0]});
      e.cap = !wr && (i == acc);
      e.wide = wide;
      q.push_back(e);
    end
    mlast_kind = req_kind;
    mlast_wr = wr;
    mce = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      in_idle = 1'b1; mce = 1'b1; exp_rv = 1'b0;
      m_s1 = 1'b1; m_s2 = 1'b1;
      cur = idle_t(1'b1);
    end else begin
      exp_rv = cur.cap;
      if (cur.cap)
        exp_rd = cur.wide ? {8'h00, dq_in[15:8], 8'h00, dq_in[7:0]} : {24'h0, dq_in[7:0]};
      if (q.size() > 0) begin
        cur = q.pop_front();
        in_idle = 1'b0;
      end else if (!in_idle) begin
        cur = idle_t(mce);
        in_idle = 1'b1;
      end else if (req_valid) begin
        build();
        cur = q.pop_front();
        in_idle = 1'b0;
      end else begin
        mce = 1'b1;
        cur = idle_t(1'b1);
      end
      m_s2 = m_s1;
      m_s1 = rb_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 ce_n", 32'(ce_n), 32'(cur.ce));
      chk("R2 cle", 32'(cle), 32'(cur.cle));
      chk("R2 ale", 32'(ale), 32'(cur.ale));
      chk("R3/R5/R6 we_n", 32'(we_n), 32'(cur.we));
      chk("R3/R5/R6 re_n", 32'(re_n), 32'(cur.re));
      chk("R9 dq_oe", 32'(dq_oe), 32'(cur.oe));
      chk("R8/R9 dq_out", 32'(dq_out), 32'(cur.dq));
      chk("R3 req_ready", 32'(req_ready), 32'(cur.idle));
      chk("R4 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
      if (exp_rv) chk("R4/R8 rsp_data", rsp_data, exp_rd);
      chk("R10 ready_evt", 32'(ready_evt), 32'(m_s1 && !m_s2));
      dq_in <= dq_in * 16'd5 + 16'h3b1d;
    end
  end

  task automatic send(input logic [1:0] kind, input logic rd, input logic wide, input logic [31:0] d);
    req_kind = kind; req_rd = rd; req_wide = wide; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (!req_ready) @(negedge clk);
    pause(3);
  endtask

  task automatic page_seq();
    send(2'd0, 1'b0, 1'b0, 32'h0000_0000);
    send(2'd1, 1'b0, 1'b0, 32'h0000_0012);
    send(2'd1, 1'b0, 1'b0, 32'h0000_0034);
    send(2'd2, 1'b1, 1'b0, 32'h0);
    send(2'd2, 1'b1, 1'b0, 32'h0);
    send(2'd2, 1'b0, 1'b0, 32'hFFFF_FFA5);
    send(2'd2, 1'b0, 1'b0, 32'h0000_005A);
    send(2'd2, 1'b1, 1'b0, 32'h0);
    send(2'd1, 1'b0, 1'b0, 32'h0000_0077);
    send(2'd3, 1'b0, 1'b0, 32'h0000_0011);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ce_n", 32'(ce_n), 32'd1);
    chk("R1 we_n", 32'(we_n), 32'd1);
    chk("R1 re_n", 32'(re_n), 32'd1);
    chk("R1 cle/ale", 32'({cle, ale}), 32'd0);
    chk("R1 dq_oe", 32'(dq_oe), 32'd0);
    chk("R1 dq_out", 32'(dq_out), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    pause(2);
    page_seq();
    t_lo = 0; t_hi = 0; t_acc = 0; t_we2re = 0; t_re2we = 0; t_re2re = 0; t_adr2dat = 0; t_cs = 0;
    page_seq();
    t_lo = 3; t_hi = 2; t_acc = 4; t_we2re = 5; t_re2we = 1; t_re2re = 2; t_adr2dat = 6; t_cs = 3;
    page_seq();
    // R8: wide writes and reads with junk in unused bytes
    send(2'd2, 1'b0, 1'b1, 32'hFFCD_EEAB);
    send(2'd2, 1'b1, 1'b1, 32'h0);
    send(2'd2, 1'b1, 1'b1, 32'h0);
    send(2'd0, 1'b0, 1'b1, 32'h5566_7788);
    drain();
    // R4: capture point beyond the strobe end
    t_lo = 1; t_hi = 2; t_acc = 9;
    send(2'd2, 1'b1, 1'b0, 32'h0);
    send(2'd2, 1'b1, 1'b1, 32'h0);
    drain();
    // R2: read flag on command and address cycles is ignored
    send(2'd0, 1'b1, 1'b0, 32'h0000_0090);
    send(2'd1, 1'b1, 1'b0, 32'h0000_0001);
    send(2'd2, 1'b1, 1'b0, 32'h0);
    drain();
    // R7: separated requests re-run chip enable setup
    send(2'd0, 1'b0, 1'b0, 32'h0000_00FF);
    pause(4);
    send(2'd0, 1'b0, 1'b0, 32'h0000_0070);
    drain();
    // R10: ready/busy transitions
    rb_n = 1'b0; pause(3);
    rb_n = 1'b1; pause(4);
    rb_n = 1'b0; pause(1);
    rb_n = 1'b1; pause(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule